// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This unit sits beside a processor and adds 16×16-bit products into one 32-bit accumulator. Each operation passes through three register stages. The first stage picks a 16-bit half of each 32-bit operand bus and extends it for the selected number format. The second stage forms the product. The third stage adds the product to the accumulator, subtracts it, or replaces the accumulator. A new operation can be accepted on every cycle. Back-to-back accumulations do not stall, because stage 3 works directly on the accumulator register that it updates.

Three number formats are supported: signed integer, unsigned integer and signed fraction. In the fraction format the product is shifted left by one bit so that a 1.15 × 1.15 product lines up as 1.31. An accumulation that leaves the range of the format sets a sticky overflow flag. When saturation is enabled for that operation, the result is clamped to the format's extreme value. The accumulator is read with a request/response pair. While a read is pending the unit refuses new operations, and it answers the read only once every earlier operation has retired.

Top module: `mac_pipe`

## Requirements
- R1: An operation accepted at clock edge N updates the accumulator at edge N+2. A read request made in the same cycle as that operation is answered (accRdValid high) only after edge N+2, and the answer holds the updated value.
- R2: Operand formatting uses the half-select bits. halfSelA=1 selects srcA[31:16] and halfSelA=0 selects srcA[15:0]. halfSelB selects the half of srcB in the same way.
- R3: With opMode=0 (signed integer), each half is taken as two's complement and the accumulator range is −2^31 to 2^31−1.
- R4: With opMode=1 (unsigned integer), each half is zero-extended and the accumulator range is 0 to 2^32−1.
- R5: With opMode=2 (signed fraction), the signed product is shifted left by one bit before it is accumulated.
- R6: In the fraction format, 0x8000 × 0x8000 gives the product 0x7FFFFFFF.
- R7: Opcode 1 adds the product to the accumulator. Opcode 2 subtracts the product from the accumulator.
- R8: Opcode 3 loads srcA into the accumulator. Opcode 4 clears the accumulator. Both of them also clear the overflow flag.
- R9: If an add or subtract leaves the format's range, ovfFlag goes high. It stays high until an opcode 3 or opcode 4 retires.
- R10: With satEn=1, an out-of-range result is clamped. For the signed formats it is clamped to 0x7FFFFFFF or 0x80000000. For the unsigned format it is clamped to 0xFFFFFFFF or 0. With satEn=0 the result wraps modulo 2^32.
- R11: Opcode 0 changes neither the accumulator nor ovfFlag.
- R12: opReady stays high across consecutive accepted operations. Three back-to-back multiply-accumulates all reach the accumulator.
- R13: While a read is pending, opReady is low. accRdValid is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opReady | output | 1 | Operation can be accepted |
| opCode | input | 3 | 0 none, 1 add product, 2 subtract product, 3 load, 4 clear |
| opMode | input | 2 | 0 signed integer, 1 unsigned integer, 2 signed fraction |
| halfSelA | input | 1 | Upper (1) or lower (0) half of srcA |
| halfSelB | input | 1 | Upper (1) or lower (0) half of srcB |
| satEn | input | 1 | Saturate instead of wrap |
| srcA | input | 32 | Operand A; load data for opcode 3 |
| srcB | input | 32 | Operand B |
| accRdReq | input | 1 | Accumulator read request |
| accRdValid | output | 1 | Read answer strobe |
| accRdData | output | 32 | Accumulator value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
An operation and an accumulator read can fall in the same cycle. The bench provokes this by raising opValid and accRdReq on the same edge with a load. It then judges the result in three ways: the answer must be absent two edges later, it must be present after the third edge, and it must carry the loaded value instead of the stale one. A second collision comes from back-to-back accumulations: each one must build on the previous result, with opReady never dropping in between.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPER_W = 16;
  localparam int ACC_W  = 32;
  localparam int BUS_W  = 32;
  localparam int EXT_W  = OPER_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int WIDE_W = PROD_W + 1;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_MAC = 3'd1, OP_MSU = 3'd2, OP_LOAD = 3'd3, OP_CLR = 3'd4
  } opcode_e;

  typedef enum logic [1:0] {
    MD_SINT = 2'd0, MD_UINT = 2'd1, MD_FRAC = 2'd2, MD_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic    capture;
    logic    advance;
    logic    accEn;
    opcode_e accOp;
  } mac_strb_t;

  function automatic logic signed [EXT_W-1:0] fmtOperand(
      input logic [BUS_W-1:0] src, input logic hi, input mode_e md);
    logic [OPER_W-1:0] h;
    h = hi ? src[BUS_W-1 -: OPER_W] : src[OPER_W-1:0];
    if (md == MD_UINT) return {1'b0, h};
    return {h[OPER_W-1], h};
  endfunction
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opValid,
  input  opcode_e   opCode,
  input  logic      accRdReq,
  output logic      opReady,
  output logic      accRdValid,
  output mac_strb_t strb
);
  logic    v1, v2, rdPending, accept;
  opcode_e op1, op2;

  assign opReady    = !rdPending;
  assign accept     = opValid && opReady;
  assign accRdValid = rdPending && !v1 && !v2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; rdPending <= 1'b0;
      op1 <= OP_NOP; op2 <= OP_NOP;
    end else begin
      v1  <= accept;
      op1 <= opCode;
      v2  <= v1;
      op2 <= op1;
      if (accRdValid) rdPending <= 1'b0;
      else if (accRdReq) rdPending <= 1'b1;
    end
  end

  assign strb.capture = accept;
  assign strb.advance = v1;
  assign strb.accEn   = v2;
  assign strb.accOp   = op2;

  assert_one_answer_R13: assert property (@(posedge clk) disable iff (!rstN)
    accRdValid |=> !accRdValid);
  assert_blocked_while_read_R13: assert property (@(posedge clk) disable iff (!rstN)
    accRdValid |-> !opReady);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mac_strb_t        strb,
  input  logic [BUS_W-1:0] srcA,
  input  logic [BUS_W-1:0] srcB,
  input  mode_e            opMode,
  input  logic             halfSelA,
  input  logic             halfSelB,
  input  logic             satEn,
  output logic [ACC_W-1:0] accVal,
  output logic             ovfVal
);
  localparam logic signed [PROD_W-1:0] FRAC_MAX = PROD_W'((64'd1 << (ACC_W-1)) - 1);
  localparam logic signed [EXT_W-1:0]  FRAC_NEG1 = -(EXT_W'(1) << (OPER_W-1));

  logic signed [EXT_W-1:0]  a1, b1;
  mode_e                    md1, md2;
  logic                     sat1, sat2;
  logic [BUS_W-1:0]         wd1, wd2;
  logic signed [PROD_W-1:0] prodFull, prodFmt, prod2;
  logic signed [WIDE_W-1:0] accExt, prodExt, wide;
  logic                     ovr;
  logic [ACC_W-1:0]         satVal, result, acc;
  logic                     ovf;

  // stage 1: operand capture and formatting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a1 <= '0; b1 <= '0; md1 <= MD_SINT; sat1 <= 1'b0; wd1 <= '0;
    end else if (strb.capture) begin
      a1   <= fmtOperand(srcA, halfSelA, opMode);
      b1   <= fmtOperand(srcB, halfSelB, opMode);
      md1  <= opMode;
      sat1 <= satEn;
      wd1  <= srcA;
    end
  end

  // stage 2: product with fractional alignment
  always_comb begin
    prodFull = PROD_W'(a1) * PROD_W'(b1);
    prodFmt  = prodFull;
    if (md1 == MD_FRAC) begin
      if (a1 == FRAC_NEG1 && b1 == FRAC_NEG1) prodFmt = FRAC_MAX;
      else prodFmt = prodFull <<< 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prod2 <= '0; md2 <= MD_SINT; sat2 <= 1'b0; wd2 <= '0;
    end else if (strb.advance) begin
      prod2 <= prodFmt;
      md2   <= md1;
      sat2  <= sat1;
      wd2   <= wd1;
    end
  end

  // stage 3: accumulate, range check, clamp
  always_comb begin
    accExt  = (md2 == MD_UINT) ? {{(WIDE_W-ACC_W){1'b0}}, acc}
                               : {{(WIDE_W-ACC_W){acc[ACC_W-1]}}, acc};
    prodExt = {prod2[PROD_W-1], prod2};
    wide    = (strb.accOp == OP_MSU) ? accExt - prodExt : accExt + prodExt;
    if (md2 == MD_UINT) begin
      ovr    = wide[WIDE_W-1] || (wide[WIDE_W-2:ACC_W] != '0);
      satVal = wide[WIDE_W-1] ? '0 : '1;
    end else begin
      ovr    = !((&wide[WIDE_W-1:ACC_W-1]) || !(|wide[WIDE_W-1:ACC_W-1]));
      satVal = wide[WIDE_W-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    end
    result = (ovr && sat2) ? satVal : wide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; ovf <= 1'b0;
    end else if (strb.accEn) begin
      case (strb.accOp)
        OP_MAC, OP_MSU: begin acc <= result; ovf <= ovf || ovr; end
        OP_LOAD:        begin acc <= wd2;    ovf <= 1'b0; end
        OP_CLR:         begin acc <= '0;     ovf <= 1'b0; end
        default: ;
      endcase
    end
  end

  assign accVal = acc;
  assign ovfVal = ovf;

  assert_frac_clamp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && md1 == MD_FRAC && a1 == FRAC_NEG1 && b1 == FRAC_NEG1)
      |=> prod2 == FRAC_MAX);
  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accEn && strb.accOp == OP_LOAD) |=> (acc == $past(wd2) && !ovf));
  assert_clear_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accEn && strb.accOp == OP_CLR) |=> (acc == '0 && !ovf));
  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !(strb.accEn && (strb.accOp == OP_LOAD || strb.accOp == OP_CLR))) |=> ovf);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accEn || strb.accOp == OP_NOP) |=> ($stable(acc) && $stable(ovf)));
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  output logic        opReady,
  input  logic [2:0]  opCode,
  input  logic [1:0]  opMode,
  input  logic        halfSelA,
  input  logic        halfSelB,
  input  logic        satEn,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic        accRdReq,
  output logic        accRdValid,
  output logic [31:0] accRdData,
  output logic        ovfFlag
);
  mac_strb_t strb;

  mac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opcode_e'(opCode)),
    .accRdReq(accRdReq), .opReady(opReady), .accRdValid(accRdValid), .strb(strb)
  );

  mac_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .srcA(srcA), .srcB(srcB),
    .opMode(mode_e'(opMode)), .halfSelA(halfSelA), .halfSelB(halfSelB),
    .satEn(satEn), .accVal(accRdData), .ovfVal(ovfFlag)
  );
endmodule

// File: tb/mac_pipe_tb.sv
module mac_pipe_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic opValid = 0, halfSelA = 0, halfSelB = 0, satEn = 0, accRdReq = 0;
  logic [2:0] opCode = 0;
  logic [1:0] opMode = 0;
  logic [31:0] srcA = 0, srcB = 0;
  logic opReady, accRdValid, ovfFlag;
  logic [31:0] accRdData;
  int nChk = 0, nErr = 0, cyc = 0;
  logic [31:0] rdVal;
  logic rdOvf;

  always #2 clk = ~clk;

  mac_pipe dut_i (.*);

  // op, mode, hA, hB, sat, a, b, expAcc, expOvf
  localparam int NV = 20;
  localparam logic [104:0] VEC [NV] = '{
    {3'd4,2'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h00000000,1'b0},
    {3'd1,2'd0,1'b0,1'b0,1'b0,32'h3,32'h5,32'h0000000F,1'b0},
    {3'd1,2'd0,1'b0,1'b0,1'b0,32'hFFFE,32'h7,32'h00000001,1'b0},
    {3'd2,2'd1,1'b0,1'b0,1'b0,32'hFFFF,32'h2,32'hFFFE0003,1'b1},
    {3'd3,2'd0,1'b0,1'b0,1'b0,32'h10,32'h0,32'h00000010,1'b0},
    {3'd1,2'd2,1'b0,1'b0,1'b0,32'h4000,32'h4000,32'h20000010,1'b0},
    {3'd1,2'd2,1'b0,1'b0,1'b0,32'h8000,32'h8000,32'hA000000F,1'b1},
    {3'd3,2'd0,1'b0,1'b0,1'b0,32'h7FFFFFF0,32'h0,32'h7FFFFFF0,1'b0},
    {3'd1,2'd0,1'b0,1'b0,1'b1,32'h100,32'h100,32'h7FFFFFFF,1'b1},
    {3'd4,2'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h00000000,1'b0},
    {3'd3,2'd0,1'b0,1'b0,1'b0,32'h80000005,32'h0,32'h80000005,1'b0},
    {3'd2,2'd0,1'b0,1'b0,1'b1,32'h3,32'h4,32'h80000000,1'b1},
    {3'd3,2'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h00000000,1'b0},
    {3'd1,2'd1,1'b1,1'b0,1'b0,32'h00030000,32'h4,32'h0000000C,1'b0},
    {3'd3,2'd1,1'b0,1'b0,1'b0,32'hFFFFFFF0,32'h0,32'hFFFFFFF0,1'b0},
    {3'd1,2'd1,1'b0,1'b0,1'b1,32'h10,32'h1,32'hFFFFFFFF,1'b1},
    {3'd0,2'd0,1'b0,1'b0,1'b0,32'h5,32'h5,32'hFFFFFFFF,1'b1},
    {3'd1,2'd1,1'b0,1'b0,1'b0,32'h0,32'h0,32'hFFFFFFFF,1'b1},
    {3'd4,2'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h00000000,1'b0},
    {3'd1,2'd2,1'b0,1'b0,1'b0,32'hC000,32'h4000,32'hE0000000,1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] md, input logic hA, input logic hB,
                       input logic sat, input logic [31:0] a, input logic [31:0] b);
    opValid = 1; opCode = op; opMode = md; halfSelA = hA; halfSelB = hB;
    satEn = sat; srcA = a; srcB = b;
    @(posedge clk); @(negedge clk);
    opValid = 0;
  endtask

  task automatic readAcc();
    accRdReq = 1;
    @(posedge clk); @(negedge clk);
    accRdReq = 0;
    for (int i = 0; i < 10 && !accRdValid; i++) begin
      @(posedge clk); @(negedge clk);
    end
    rdVal = accRdData; rdOvf = ovfFlag;
    check("R13 answer present", {31'b0, accRdValid}, 32'd1);
    @(posedge clk); @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nErr++; nChk++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // reset state
    check("R9 reset ovf", {31'b0, ovfFlag}, 0);
    check("R13 reset ready", {31'b0, opReady}, 1);
    check("R13 reset no answer", {31'b0, accRdValid}, 0);
    readAcc();
    check("R8 reset acc", rdVal, 0);

    // vector walk
    for (int k = 0; k < NV; k++) begin
      logic [104:0] v;
      v = VEC[k];
      issue(v[104:102], v[101:100], v[99], v[98], v[97], v[96:65], v[64:33]);
      readAcc();
      check($sformatf("R3 R4 R5 R7 R10 vector %0d acc", k), rdVal, v[32:1]);
      check($sformatf("R9 R8 R11 vector %0d ovf", k), {31'b0, rdOvf}, {31'b0, v[0]});
    end

    // back-to-back accumulations, no stall
    issue(3'd4, 2'd0, 0, 0, 0, 0, 0);
    opValid = 1; opCode = 3'd1; opMode = 0; satEn = 0; halfSelA = 0; halfSelB = 0;
    srcA = 2; srcB = 3;
    @(posedge clk); @(negedge clk);
    check("R12 ready second", {31'b0, opReady}, 1);
    srcA = 4; srcB = 5;
    @(posedge clk); @(negedge clk);
    check("R12 ready third", {31'b0, opReady}, 1);
    srcA = 6; srcB = 7;
    @(posedge clk); @(negedge clk);
    opValid = 0;
    readAcc();
    check("R12 back-to-back sum", rdVal, 32'd68);

    // operation and read in the same cycle
    opValid = 1; opCode = 3'd3; srcA = 32'h1234ABCD; accRdReq = 1;
    @(posedge clk); @(negedge clk);
    opValid = 0; accRdReq = 0;
    check("R13 ready low while pending", {31'b0, opReady}, 0);
    @(posedge clk); @(negedge clk);
    check("R1 no answer after two edges", {31'b0, accRdValid}, 0);
    @(posedge clk); @(negedge clk);
    check("R1 answer after three edges", {31'b0, accRdValid}, 1);
    check("R1 answer holds load", accRdData, 32'h1234ABCD);
    @(posedge clk); @(negedge clk);
    check("R13 single answer", {31'b0, accRdValid}, 0);
    check("R13 ready restored", {31'b0, opReady}, 1);

    // upper half of B in signed mode
    issue(3'd4, 2'd0, 0, 0, 0, 0, 0);
    issue(3'd1, 2'd0, 0, 1, 0, 32'h00000003, 32'hFFFE0000);
    readAcc();
    check("R2 R3 upper half B", rdVal, 32'hFFFFFFFA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule